// File: doc/BRIEF.md
# Universal Bus Transceiver Channel

This block is a two-way data path between an A port and a B port, 17 bits wide by default. Each direction has its own storage register and its own four controls: an active-low output enable, a latch enable, a port clock and an active-low clock enable. Together these controls put the direction into one of four transfer modes. In pass-through mode the output follows the input. In hold mode the stored word is kept. In edge-capture mode a rising port-clock edge loads the input. In inhibit mode the port clock is ignored.

Each pin group is modelled as three separate vectors: an input, an output value and an output-enable. The port clocks are treated as data. A free-running system clock samples them, and a rising edge is found by comparing the current level with the level seen one system cycle earlier, so the design has no latches. The block also drives a copy of the A-to-B port clock onto a dedicated clock output, and passes an incoming clock through to the A side.

Top module: `ubt_channel`

## Requirements
- R1: While `ab_le` is 1, `b_out` equals `a_in` in the same cycle, and the A-to-B register loads `a_in` at every system clock edge. When `ab_le` falls, `b_out` shows the word that was loaded at the last system edge with `ab_le` high.
- R2: While `ab_le` is 0 and `ab_ce_n` is 0, `b_out` holds the stored word whenever `ab_clk` makes no low-to-high transition, whatever `a_in` does.
- R3: While `ab_le` is 0 and `ab_ce_n` is 0, a system edge that sees `ab_clk` high after it was low at the previous system edge stores `a_in`. `b_out` shows that word right after that edge.
- R4: While `ab_le` is 0 and `ab_ce_n` is 1, rising edges of `ab_clk` leave the stored word unchanged.
- R5: `ab_oe_n` is active low. When it is 1, every bit of `b_oe` is 0. When it is 0 and reset is released, every bit is 1. The stored word keeps following R1 to R4 while the output is disabled, and it appears again when the output is re-enabled.
- R6: The B-to-A direction follows R1 to R5 using `b_in`, `a_out`, `a_oe`, `ba_oe_n`, `ba_le`, `ba_clk` and `ba_ce_n`. It has no effect on the A-to-B direction, and the A-to-B direction has no effect on it.
- R7: `clk_out` equals `ab_clk` and `clk_to_a` equals `clk_in` combinationally, in every mode and during reset.
- R8: A port clock that is already high when reset is released does not count as a rising edge. A capture needs a low level seen after reset, followed by a high level.
- R9: While `rst_n` is 0, `a_oe` and `b_oe` are all zeros and both registers are cleared. After release, with the latch enables low, both outputs show zero until a load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the port clocks and the controls |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_in | input | W | Value received on the A pins |
| a_out | output | W | Value driven onto the A pins (B-to-A data) |
| a_oe | output | W | Per-bit drive enable for the A pins |
| b_in | input | W | Value received on the B pins |
| b_out | output | W | Value driven onto the B pins (A-to-B data) |
| b_oe | output | W | Per-bit drive enable for the B pins |
| ab_oe_n | input | 1 | A-to-B output enable, active low |
| ab_le | input | 1 | A-to-B latch enable, high selects pass-through |
| ab_clk | input | 1 | A-to-B port clock |
| ab_ce_n | input | 1 | A-to-B clock enable, active low |
| ba_oe_n | input | 1 | B-to-A output enable, active low |
| ba_le | input | 1 | B-to-A latch enable, high selects pass-through |
| ba_clk | input | 1 | B-to-A port clock |
| ba_ce_n | input | 1 | B-to-A clock enable, active low |
| clk_out | output | 1 | Copy of `ab_clk` |
| clk_in | input | 1 | Incoming clock to be repeated on the A side |
| clk_to_a | output | 1 | Copy of `clk_in` |

## Verification
A corrupted storage register stays hidden while its latch enable is high. It shows up on the output pins in the first cycle after the latch enable drops, or right after the output is re-enabled. A missed or extra port-clock edge changes the output word one system cycle after the edge, and the checks sample in exactly that cycle. The bench also looks for a lost reset, a swapped enable polarity or a leak between the two directions: it watches the opposite direction's output and the enable vectors at the ports while the other direction is being exercised.

// File: rtl/ubt_pkg.sv
package ubt_pkg;

  // Transfer mode of one direction for the current system cycle.
  typedef enum logic [1:0] {
    XM_PASS    = 2'd0,
    XM_HOLD    = 2'd1,
    XM_EDGE    = 2'd2,
    XM_INHIBIT = 2'd3
  } xfer_mode_e;

  // The latch enable wins over everything. With it low, the clock enable
  // decides whether a detected port-clock rise may store.
  function automatic xfer_mode_e pick_mode(input logic le,
                                           input logic ce_n,
                                           input logic rise);
    if (le)        return XM_PASS;
    else if (ce_n) return XM_INHIBIT;
    else if (rise) return XM_EDGE;
    else           return XM_HOLD;
  endfunction

  // Modes that write the storage register.
  function automatic logic mode_loads(input xfer_mode_e m);
    return (m == XM_PASS) || (m == XM_EDGE);
  endfunction

  // Value presented on the pins: live input in pass mode, stored word otherwise.
  function automatic logic [63:0] pin_value(input logic le,
                                            input logic [63:0] live,
                                            input logic [63:0] stored);
    return le ? live : stored;
  endfunction

endpackage

// File: rtl/ubt_edge_det.sv
module ubt_edge_det #(
  parameter logic IDLE_LEVEL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic rise
);

  logic prev_q;

  // Reset to high, so a clock that is already high at release is not a rise.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= IDLE_LEVEL;
    else        prev_q <= lvl;
  end

  assign rise = lvl & ~prev_q;

endmodule

// File: rtl/ubt_store.sv
module ubt_store #(
  parameter int W = 17
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] din,
  output logic [W-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= din;
  end

endmodule

// File: rtl/ubt_path_store.sv
module ubt_path_store
  import ubt_pkg::*;
#(
  parameter int W = 17
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  input  logic         le,
  input  logic         pclk,
  input  logic         ce_n,
  output logic [W-1:0] q
);

  logic       pclk_rise;
  xfer_mode_e mode;
  logic       load;

  ubt_edge_det #(.IDLE_LEVEL(1'b1)) u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .lvl   (pclk),
    .rise  (pclk_rise)
  );

  always_comb begin
    mode = pick_mode(le, ce_n, pclk_rise);
    load = mode_loads(mode);
  end

  ubt_store #(.W(W)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (load),
    .din   (din),
    .q     (q)
  );

endmodule

// File: rtl/ubt_channel.sv
module ubt_channel
  import ubt_pkg::*;
#(
  parameter int W = 17
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] a_in,
  output logic [W-1:0] a_out,
  output logic [W-1:0] a_oe,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] b_out,
  output logic [W-1:0] b_oe,
  input  logic         ab_oe_n,
  input  logic         ab_le,
  input  logic         ab_clk,
  input  logic         ab_ce_n,
  input  logic         ba_oe_n,
  input  logic         ba_le,
  input  logic         ba_clk,
  input  logic         ba_ce_n,
  output logic         clk_out,
  input  logic         clk_in,
  output logic         clk_to_a
);

  localparam int NDIR = 2;  // index 0: A to B, index 1: B to A

  logic [NDIR-1:0][W-1:0] src;
  logic [NDIR-1:0][W-1:0] stored;
  logic [NDIR-1:0][W-1:0] shown;
  logic [NDIR-1:0]        le_v;
  logic [NDIR-1:0]        pclk_v;
  logic [NDIR-1:0]        ce_n_v;
  logic [NDIR-1:0]        oe_n_v;
  logic [NDIR-1:0]        drive;

  logic [W-1:0] ab_q;
  logic [W-1:0] ba_q;

  assign src    = {b_in, a_in};
  assign le_v   = {ba_le, ab_le};
  assign pclk_v = {ba_clk, ab_clk};
  assign ce_n_v = {ba_ce_n, ab_ce_n};
  assign oe_n_v = {ba_oe_n, ab_oe_n};

  for (genvar d = 0; d < NDIR; d++) begin : g_dir
    logic [63:0] live_w;
    logic [63:0] stored_w;
    logic [63:0] mux_w;

    ubt_path_store #(.W(W)) u_path (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (src[d]),
      .le    (le_v[d]),
      .pclk  (pclk_v[d]),
      .ce_n  (ce_n_v[d]),
      .q     (stored[d])
    );

    assign live_w   = 64'(src[d]);
    assign stored_w = 64'(stored[d]);
    assign mux_w    = pin_value(le_v[d], live_w, stored_w);
    assign shown[d] = mux_w[W-1:0];
    assign drive[d] = rst_n & ~oe_n_v[d];
  end

  assign ab_q  = stored[0];
  assign ba_q  = stored[1];

  assign b_out = shown[0];
  assign a_out = shown[1];
  assign b_oe  = {W{drive[0]}};
  assign a_oe  = {W{drive[1]}};

  // Clock repeaters
  assign clk_out  = ab_clk;
  assign clk_to_a = clk_in;

endmodule

// File: rtl/ubt_channel_chk.sv
module ubt_channel_chk #(
  parameter int W = 17
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] a_in,
  input logic [W-1:0] a_out,
  input logic [W-1:0] b_in,
  input logic [W-1:0] b_out,
  input logic [W-1:0] a_oe,
  input logic [W-1:0] b_oe,
  input logic         ab_oe_n,
  input logic         ab_le,
  input logic         ab_clk,
  input logic         ab_ce_n,
  input logic         ba_oe_n,
  input logic         ba_le,
  input logic         ba_clk,
  input logic         ba_ce_n,
  input logic [W-1:0] ab_q,
  input logic [W-1:0] ba_q
);

  // R1
  ab_pass_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ab_le |-> (b_out == a_in));

  // R1
  ab_pass_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ab_le |=> (ab_q == $past(a_in)));

  // R2
  ab_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ab_le && !ab_ce_n && !(ab_clk && !$past(ab_clk))) |=> $stable(ab_q));

  // R3
  ab_edge_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !ab_le && !ab_ce_n && ab_clk && !$past(ab_clk))
      |=> (ab_q == $past(a_in)));

  // R4
  ab_inhibit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ab_le && ab_ce_n) |=> $stable(ab_q));

  // R5
  ab_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ab_oe_n |-> (b_oe == '0));

  // R6
  ba_pass_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ba_le |-> (a_out == b_in));

  // R6
  ba_inhibit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ba_le && ba_ce_n) |=> $stable(ba_q));

  // R6
  ba_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ba_oe_n |-> (a_oe == '0));

endmodule

bind ubt_channel ubt_channel_chk #(.W(W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .a_in    (a_in),
  .a_out   (a_out),
  .b_in    (b_in),
  .b_out   (b_out),
  .a_oe    (a_oe),
  .b_oe    (b_oe),
  .ab_oe_n (ab_oe_n),
  .ab_le   (ab_le),
  .ab_clk  (ab_clk),
  .ab_ce_n (ab_ce_n),
  .ba_oe_n (ba_oe_n),
  .ba_le   (ba_le),
  .ba_clk  (ba_clk),
  .ba_ce_n (ba_ce_n),
  .ab_q    (ab_q),
  .ba_q    (ba_q)
);

// File: tb/test_ubt_channel.sv
module test_ubt_channel;

  localparam int W = 17;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [W-1:0] a_in, b_in;
  logic [W-1:0] a_out, a_oe, b_out, b_oe;
  logic ab_oe_n, ab_le, ab_clk, ab_ce_n;
  logic ba_oe_n, ba_le, ba_clk, ba_ce_n;
  logic clk_out, clk_in, clk_to_a;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  ubt_channel #(.W(W)) i_ubt_channel (
    .clk(clk), .rst_n(rst_n),
    .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_out(b_out), .b_oe(b_oe),
    .ab_oe_n(ab_oe_n), .ab_le(ab_le), .ab_clk(ab_clk), .ab_ce_n(ab_ce_n),
    .ba_oe_n(ba_oe_n), .ba_le(ba_le), .ba_clk(ba_clk), .ba_ce_n(ba_ce_n),
    .clk_out(clk_out), .clk_in(clk_in), .clk_to_a(clk_to_a)
  );

  typedef struct packed {
    logic [3:0]   req;
    logic         le;
    logic         ce_n;
    logic         pclk;
    logic         oe_n;
    logic [W-1:0] din;
    logic [W-1:0] exp_out;
    logic         exp_en;
  } vec_t;

  // A-to-B walk. State before the first row: register 0, le 0, ce_n 1, clock low.
  localparam vec_t TBL [0:12] = '{
    '{4'd1, 1'b1, 1'b1, 1'b0, 1'b0, 17'h1A5A5, 17'h1A5A5, 1'b1},
    '{4'd1, 1'b1, 1'b1, 1'b0, 1'b0, 17'h00F0F, 17'h00F0F, 1'b1},
    '{4'd1, 1'b0, 1'b1, 1'b0, 1'b0, 17'h12345, 17'h00F0F, 1'b1},
    '{4'd2, 1'b0, 1'b0, 1'b0, 1'b0, 17'h0AAAA, 17'h00F0F, 1'b1},
    '{4'd3, 1'b0, 1'b0, 1'b1, 1'b0, 17'h0BBBB, 17'h0BBBB, 1'b1},
    '{4'd2, 1'b0, 1'b0, 1'b1, 1'b0, 17'h0CCCC, 17'h0BBBB, 1'b1},
    '{4'd2, 1'b0, 1'b0, 1'b0, 1'b0, 17'h0DDDD, 17'h0BBBB, 1'b1},
    '{4'd4, 1'b0, 1'b1, 1'b1, 1'b0, 17'h1FFFF, 17'h0BBBB, 1'b1},
    '{4'd4, 1'b0, 1'b1, 1'b0, 1'b0, 17'h11111, 17'h0BBBB, 1'b1},
    '{4'd3, 1'b0, 1'b0, 1'b1, 1'b0, 17'h11111, 17'h11111, 1'b1},
    '{4'd5, 1'b0, 1'b0, 1'b0, 1'b1, 17'h05555, 17'h11111, 1'b0},
    '{4'd5, 1'b0, 1'b0, 1'b1, 1'b1, 17'h06666, 17'h06666, 1'b0},
    '{4'd5, 1'b0, 1'b1, 1'b1, 1'b0, 17'h00000, 17'h06666, 1'b1}
  };

  task automatic check(input string req, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // One system cycle: inputs were set at a falling edge, sample 1 ns after the rise.
  task automatic step();
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    a_in = '0; b_in = '0;
    ab_oe_n = 1'b0; ab_le = 1'b0; ab_clk = 1'b0; ab_ce_n = 1'b1;
    ba_oe_n = 1'b1; ba_le = 1'b0; ba_clk = 1'b0; ba_ce_n = 1'b1;
    clk_in = 1'b0;
    #1;
    // R9: enables off during reset even with ab_oe_n low
    check("R9", "b_oe in reset", b_oe, '0);
    check("R9", "a_oe in reset", a_oe, '0);
    step(); step();
    @(negedge clk) rst_n = 1'b1;
    step();
    check("R9", "b_out after reset", b_out, '0);
    check("R9", "a_out after reset", a_out, '0);

    for (int i = 0; i < 13; i++) begin
      @(negedge clk);
      ab_le   = TBL[i].le;
      ab_ce_n = TBL[i].ce_n;
      ab_clk  = TBL[i].pclk;
      ab_oe_n = TBL[i].oe_n;
      a_in    = TBL[i].din;
      step();
      check($sformatf("R%0d", TBL[i].req), $sformatf("row %0d b_out", i),
            b_out, TBL[i].exp_out);
      check($sformatf("R%0d", TBL[i].req), $sformatf("row %0d b_oe", i),
            b_oe, TBL[i].exp_en ? '1 : '0);
    end

    // R6: B-to-A path, A-to-B held in inhibit with word 06666
    @(negedge clk);
    ba_oe_n = 1'b0; ba_le = 1'b1; b_in = 17'h13579;
    step();
    check("R6", "a_out pass", a_out, 17'h13579);
    check("R6", "a_oe on", a_oe, '1);
    check("R6", "b_out untouched", b_out, 17'h06666);
    @(negedge clk);
    ba_le = 1'b0; ba_ce_n = 1'b0; ba_clk = 1'b0; b_in = 17'h02468;
    step();
    check("R6", "a_out frozen", a_out, 17'h13579);
    @(negedge clk) ba_clk = 1'b1;
    step();
    check("R6", "a_out captured", a_out, 17'h02468);
    check("R6", "b_out still untouched", b_out, 17'h06666);
    @(negedge clk) ba_oe_n = 1'b1;
    step();
    check("R6", "a_oe off", a_oe, '0);

    // R7: clock repeaters
    @(negedge clk);
    ab_clk = 1'b0; clk_in = 1'b1;
    #1;
    check("R7", "clk_out low", W'(clk_out), W'(1'b0));
    check("R7", "clk_to_a high", W'(clk_to_a), W'(1'b1));
    ab_clk = 1'b1; clk_in = 1'b0;
    #1;
    check("R7", "clk_out high", W'(clk_out), W'(1'b1));
    check("R7", "clk_to_a low", W'(clk_to_a), W'(1'b0));

    // R9 and R8: second reset clears both registers, port clock high at release
    @(negedge clk);
    rst_n = 1'b0; ab_oe_n = 1'b0; ba_oe_n = 1'b0;
    ab_le = 1'b0; ab_ce_n = 1'b0; ab_clk = 1'b1; a_in = 17'h15555;
    #1;
    check("R9", "b_oe in second reset", b_oe, '0);
    check("R9", "b_out cleared", b_out, '0);
    check("R9", "a_out cleared", a_out, '0);
    step();
    @(negedge clk) rst_n = 1'b1;
    step(); step(); step();
    check("R8", "no capture from high clock at release", b_out, '0);
    @(negedge clk) ab_clk = 1'b0;
    step();
    check("R8", "still empty after low", b_out, '0);
    @(negedge clk) ab_clk = 1'b1;
    step();
    check("R8", "capture after low-high", b_out, 17'h15555);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule